// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transmitter

This block plays the peripheral role on a two-wire PS/2 link, the role a keyboard or mouse takes, and sends one byte at a time to the host. Both bus wires are open-drain. The block only ever pulls a wire low through an output-enable, or releases it. It reads both wires back through two-flop synchronizers. The block makes the serial clock itself from a microsecond tick. That tick is derived from the system clock frequency parameter, which must be at least 3 MHz.

Local logic offers a byte on a valid/ready stream input. `s_ready` is high only when the block is idle and both wires read high. A byte is taken on any rising system clock edge where `s_valid` and `s_ready` are both high. While `s_ready` is low, the producer holds `s_valid` and `s_data` steady. Nothing is lost by waiting.

During a frame the host may hold the clock wire low. The block notices this when it releases the clock for a high phase and reads it back low. It then lets go of both wires, pulses `aborted`, and keeps the byte. When the bus is idle again, it sends the same frame again from the start bit.

Top module: `ps2_dev_tx`

## Requirements
- R1: `s_ready` is high only while the block is idle and both synchronized wire readbacks are high. A byte is taken when `s_valid` and `s_ready` are both high at a clock edge, and `busy` rises on the next cycle.
- R2: A frame has 11 clock falling edges. The bit seen at each falling edge, in order, is: a start bit of 0, the eight data bits with bit 0 first, a parity bit, and a stop bit of 1.
- R3: The parity bit is 1 exactly when the data byte has an even number of ones. The nine bits therefore always hold an odd count of ones.
- R4: Every clock low phase and every clock high phase within a frame lasts between 30 and 50 µs. With the default HALF_US of 40, each phase is 40 µs.
- R5: The data wire changes only while the clock wire is high. Inside a frame, it changes 15 to 25 µs after the preceding rising edge (SETUP_US, default 20).
- R6: From reset, both output-enables, `busy`, `done` and `aborted` are low. `s_ready` goes high within a few cycles if the bus is idle.
- R7: If the clock wire reads low during a high phase that the block has released, the block pulses `aborted` for one cycle. In that cycle both output-enables are low and `busy` stays high.
- R8: After an abort, the block leaves the clock wire alone until both wires read high. It then resends the kept byte as a complete frame.
- R9: `done` pulses for one cycle, 30 to 50 µs after the stop bit's rising clock edge. `busy` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Byte offered by local logic |
| s_data | input | 8 | Byte to send |
| s_ready | output | 1 | Block accepts a byte this cycle |
| ps2_clk_in | input | 1 | Readback of the bus clock wire |
| ps2_dat_in | input | 1 | Readback of the bus data wire |
| ps2_clk_oe | output | 1 | High pulls the bus clock wire low |
| ps2_dat_oe | output | 1 | High pulls the bus data wire low |
| busy | output | 1 | A byte is held, in flight or awaiting retry |
| done | output | 1 | One-cycle pulse: frame completed |
| aborted | output | 1 | One-cycle pulse: host inhibit seen, frame dropped |

## Verification
A wrong bit index or a stale shift register shows up at the next host falling edge as a wrong bit in the frame. It can therefore be seen within about 80 µs of the fault. Faults in the phase counters or the tick divider show at the following clock wire transition: a half period measured outside 30–50 µs, or a data change outside the mid-cell window. A broken inhibit path shows within a few microseconds of the host holding the clock: either no `aborted` pulse, or clock pulses that continue. After the host releases the bus, a retry that fails to restart the frame shows in the frame's content and bit count.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_HOLD
  } ps2tx_state_e;
endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ps2tx_us_tick.sv
module ps2tx_us_tick #(
  parameter int CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(CYC - 1)) && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (cnt == CW'(CYC - 1)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R4: the microsecond base never fires on consecutive cycles
  a_r4_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((CYC == 1) || !tick));
endmodule

// File: rtl/ps2tx_frame.sv
module ps2tx_frame
  import ps2tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] frame
);
  logic par_odd;

  // parity set when the byte holds an even count of ones
  assign par_odd = ~^data;
  assign frame   = {1'b1, par_odd, data, 1'b0};
endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
  import ps2tx_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int HALF_US  = 40,
  parameter int SETUP_US = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  output logic        s_ready,
  input  logic        ps2_clk_in,
  input  logic        ps2_dat_in,
  output logic        ps2_clk_oe,
  output logic        ps2_dat_oe,
  output logic        busy,
  output logic        done,
  output logic        aborted
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int CNT_W      = $clog2(HALF_US + 1);
  localparam int BIT_W      = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  logic               sclk, sdat;
  logic [FRAME_W-1:0] frame_nxt, frame_q;
  logic               us_tick, phase_go;
  ps2tx_state_e       state;
  logic [CNT_W-1:0]   us_cnt;
  logic [BIT_W-1:0]   bit_idx;
  logic               clk_oe_q, dat_oe_q, done_q, abort_q;
  logic               accept, in_high, inhibit, phase_end, setup_pt;

  ps2tx_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ps2_clk_in, ps2_dat_in}),
    .q     ({sclk, sdat})
  );

  ps2tx_frame u_frame (
    .data  (s_data),
    .frame (frame_nxt)
  );

  ps2tx_us_tick #(.CYC(CYC_PER_US)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (phase_go),
    .tick  (us_tick)
  );

  assign s_ready   = (state == ST_IDLE) && sclk && sdat;
  assign accept    = s_valid && s_ready;
  assign in_high   = (state == ST_HIGH) || (state == ST_TAIL);
  // one microsecond after release leaves room for the synchronizer delay
  assign inhibit   = in_high && (us_cnt != '0) && !sclk;
  assign phase_end = us_tick && (us_cnt == CNT_W'(HALF_US - 1));
  assign setup_pt  = us_tick && (us_cnt == CNT_W'(SETUP_US - 1)) && (state == ST_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      us_cnt   <= '0;
      bit_idx  <= '0;
      frame_q  <= '0;
      clk_oe_q <= 1'b0;
      dat_oe_q <= 1'b0;
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
      phase_go <= 1'b0;
    end else begin
      done_q   <= 1'b0;
      abort_q  <= 1'b0;
      phase_go <= 1'b0;
      if (us_tick) us_cnt <= us_cnt + 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            frame_q  <= frame_nxt;
            bit_idx  <= '0;
            us_cnt   <= '0;
            phase_go <= 1'b1;
            state    <= ST_HIGH;
          end
        end
        ST_HIGH, ST_TAIL: begin
          if (inhibit) begin
            clk_oe_q <= 1'b0;
            dat_oe_q <= 1'b0;
            abort_q  <= 1'b1;
            state    <= ST_HOLD;
          end else begin
            if (setup_pt) dat_oe_q <= ~frame_q[bit_idx];
            if (phase_end) begin
              us_cnt   <= '0;
              phase_go <= 1'b1;
              if (state == ST_HIGH) begin
                clk_oe_q <= 1'b1;
                state    <= ST_LOW;
              end else begin
                done_q   <= 1'b1;
                state    <= ST_IDLE;
              end
            end
          end
        end
        ST_LOW: begin
          if (phase_end) begin
            clk_oe_q <= 1'b0;
            us_cnt   <= '0;
            phase_go <= 1'b1;
            if (bit_idx == LAST_BIT) begin
              state <= ST_TAIL;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              state   <= ST_HIGH;
            end
          end
        end
        ST_HOLD: begin
          if (sclk && sdat) begin
            bit_idx  <= '0;
            us_cnt   <= '0;
            phase_go <= 1'b1;
            state    <= ST_HIGH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ps2_clk_oe = clk_oe_q;
  assign ps2_dat_oe = dat_oe_q;
  assign busy       = (state != ST_IDLE);
  assign done       = done_q;
  assign aborted    = abort_q;

  // R1: a handshake always starts a transfer
  a_r1_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> busy);

  // R5: data wire moves only while the block leaves the clock released
  a_r5_data_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ps2_dat_oe != $past(ps2_dat_oe)) |-> (!$past(ps2_clk_oe) && !ps2_clk_oe));

  // R6: nothing pulled while no byte is held
  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ps2_clk_oe && !ps2_dat_oe));

  // R7: abort lets go of both wires and keeps the byte
  a_r7_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> (!ps2_clk_oe && !ps2_dat_oe && busy));

  // R8: no clocking toward the host after an abort
  a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(aborted) |-> !ps2_clk_oe);

  // R9: done is a single cycle and ends busy
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !aborted));
endmodule

// File: tb/ps2_dev_tx_test.sv
module ps2_dev_tx_test;
  localparam int CLK_HZ = 4_000_000;
  localparam int CPU    = CLK_HZ / 1_000_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       host_hold = 1'b0;
  logic       host_dlow = 1'b0;
  logic       s_ready, clk_oe, dat_oe, busy, done, aborted;
  logic       cl, dl;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign cl = !(clk_oe || host_hold);
  assign dl = !(dat_oe || host_dlow);

  ps2_dev_tx #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .ps2_clk_in(cl), .ps2_dat_in(dl), .ps2_clk_oe(clk_oe), .ps2_dat_oe(dat_oe),
    .busy(busy), .done(done), .aborted(aborted)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit even_ones(input logic [7:0] b);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(b[i]);
    return (c % 2) == 0;
  endfunction

  function automatic logic [10:0] exp_frame(input logic [7:0] b);
    return {1'b1, even_ones(b), b, 1'b0};
  endfunction

  // host-side monitor
  int cyc = 0, nb = 0, t_fall = 0, t_rise = 0;
  bit fvalid = 0, rvalid = 0;
  logic pcl = 1'b1, pdl = 1'b1;
  logic [10:0] rx = '0, last_rx = '0;
  int last_nb = 0, done_cnt = 0, abort_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n || host_hold || aborted) begin
      nb = 0; fvalid = 0; rvalid = 0;
      if (aborted) abort_cnt++;
    end else begin
      if (pcl && !cl) begin
        if (rvalid) chk((cyc - t_rise) >= 30*CPU && (cyc - t_rise) <= 50*CPU,
                        "R4 high phase cycles", cyc - t_rise, 40*CPU);
        if (nb < 11) rx[nb] = dl;
        nb++;
        t_fall = cyc; fvalid = 1;
      end
      if (!pcl && cl) begin
        if (fvalid) chk((cyc - t_fall) >= 30*CPU && (cyc - t_fall) <= 50*CPU,
                        "R4 low phase cycles", cyc - t_fall, 40*CPU);
        t_rise = cyc; rvalid = 1;
      end
      if (busy && (pdl != dl)) begin
        chk(cl, "R5 data change with clock high", int'(cl), 1);
        if (rvalid) chk((cyc - t_rise) >= 15*CPU && (cyc - t_rise) <= 25*CPU,
                        "R5 setup after rise", cyc - t_rise, 20*CPU);
      end
      if (done) begin
        chk(rvalid && (cyc - t_rise) >= 30*CPU && (cyc - t_rise) <= 50*CPU,
            "R9 done after stop cycle", cyc - t_rise, 40*CPU);
        chk(!busy, "R9 busy falls with done", int'(busy), 0);
        last_rx = rx; last_nb = nb;
        nb = 0; fvalid = 0; rvalid = 0;
        done_cnt++;
      end
    end
    pcl = cl; pdl = dl;
  end

  task automatic handshake(input logic [7:0] b);
    int w = 0;
    s_data = b; s_valid = 1'b1;
    while (!s_ready && w < 20000) begin @(negedge clk); w++; end
    chk(s_ready, "R1 ready seen", int'(s_ready), 1);
    @(negedge clk);
    s_valid = 1'b0;
    chk(busy, "R1 busy after accept", int'(busy), 1);
  endtask

  task automatic wait_done(input logic [7:0] b, input string req);
    int w = 0;
    int start = done_cnt;
    while (done_cnt == start && w < 20000) begin @(negedge clk); w++; end
    chk(done_cnt != start, {req, " done seen"}, done_cnt - start, 1);
    chk(last_nb == 11, "R2 falling edge count", last_nb, 11);
    chk(last_rx == exp_frame(b), {req, " R2 frame bits"}, int'(last_rx), int'(exp_frame(b)));
    chk(last_rx[9] == even_ones(b), "R3 parity bit", int'(last_rx[9]), int'(even_ones(b)));
    @(negedge clk);
    chk(!done, "R9 done one cycle", int'(done), 0);
  endtask

  task automatic abort_case(input logic [7:0] b, input int nfall, input bit in_low);
    int w = 0;
    int a0 = abort_cnt;
    handshake(b);
    while (nb < nfall && w < 20000) begin @(negedge clk); w++; end
    if (!in_low) begin
      w = 0;
      while (!cl && w < 1000) begin @(negedge clk); w++; end
    end
    repeat (40) @(negedge clk);
    host_hold = 1'b1;
    w = 0;
    while (abort_cnt == a0 && w < 1000) begin @(negedge clk); w++; end
    chk(abort_cnt == a0 + 1, "R7 aborted pulse", abort_cnt - a0, 1);
    chk(!clk_oe && !dat_oe && busy, "R7 released and busy", int'({clk_oe, dat_oe, busy}), 1);
    repeat (800) begin
      @(negedge clk);
      if (clk_oe || !busy || s_ready) chk(0, "R8 waits during inhibit", int'({clk_oe, busy}), 1);
    end
    chk(!clk_oe && busy, "R8 still holding byte", int'(busy), 1);
    host_hold = 1'b0;
    wait_done(b, "R8 retry");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!clk_oe && !dat_oe && !busy && !done && !aborted, "R6 reset outputs",
        int'({clk_oe, dat_oe, busy, done, aborted}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(s_ready, "R6 ready after reset", int'(s_ready), 1);

    // R1: inhibited clock blocks acceptance
    host_hold = 1'b1;
    repeat (10) @(negedge clk);
    chk(!s_ready, "R1 ready low with clock held", int'(s_ready), 0);
    s_data = 8'h3C; s_valid = 1'b1;
    repeat (200) @(negedge clk);
    chk(!busy, "R1 no accept while inhibited", int'(busy), 0);
    host_hold = 1'b0;
    handshake(8'h3C);
    wait_done(8'h3C, "R1 held byte");

    // R1: data wire low blocks acceptance
    host_dlow = 1'b1;
    repeat (10) @(negedge clk);
    chk(!s_ready, "R1 ready low with data held", int'(s_ready), 0);
    host_dlow = 1'b0;
    repeat (5) @(negedge clk);
    chk(s_ready, "R1 ready back when idle", int'(s_ready), 1);

    // directed corners
    handshake(8'h00); wait_done(8'h00, "R2 zero");
    handshake(8'hFF); wait_done(8'hFF, "R2 ones");
    handshake(8'h01); wait_done(8'h01, "R3 odd weight");
    handshake(8'hA5); wait_done(8'hA5, "R2 mixed");

    // random bytes
    for (int k = 0; k < 10; k++) begin
      logic [7:0] b;
      b = 8'($urandom);
      handshake(b);
      wait_done(b, "R2 random");
    end

    // inhibit during a low phase and during a high phase
    abort_case(8'h5A, 4, 1'b1);
    abort_case(8'hC3, 7, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule